// File: doc/BRIEF.md
# Bus Address Decoder with Protection

This block sits on a shared system bus beside the arbiter and watches the transfer that the current bus owner presents. It compares the address against a set of regions. Each region has a base, a mask and two attribute bits. From that comparison it drives one select line per slave. It also acts as a basic protection unit. The two-bit protection field travels with the address. A user-mode access to a region marked privileged-only is refused, and so is an instruction fetch from a region marked no-execute. A refused access gets an abort response.

The decision is taken from the address phase and registered, so selects, abort and wait belong to the data phase that follows. The selected slave stretches the data phase through its own wait line, and the decoder forwards it. While that stretch lasts, the decoder keeps its decision and ignores the address lines. When no slave is selected, the decoder itself answers: the wait response is low, and the abort is high only for a refused or unmapped data transfer. The pins are plain control signals. The only back-pressure is the slave wait, which stalls the next decode.

Encodings used throughout:
- Transfer type: 00 idle, 01 address-only, 10 nonsequential, 11 sequential.
- Protection bit 0: 1 means data, 0 means instruction fetch.
- Protection bit 1: 1 means privileged, 0 means user.

Top module: `bdp_decoder`

## Requirements
- R1: During and right after reset, all slave selects are low and both the bus wait and bus abort are low.
- R2: A nonsequential or sequential transfer whose address satisfies (addr & mask) == base for a permitted region i drives select bit i alone in the next cycle, with abort low.
- R3: When several regions match one address, only the lowest-numbered matching region is selected, and its attributes alone decide protection.
- R4: An idle (00) or address-only (01) transfer asserts no select and no abort in the next cycle.
- R5: A user access (protection bit 1 = 0) to a privileged-only region asserts no select and raises abort for one cycle, with wait low.
- R6: An instruction fetch (protection bit 0 = 0) to a no-execute region asserts no select and raises abort for one cycle, with wait low.
- R7: A data transfer that matches no region asserts no select and raises abort for one cycle, with wait low.
- R8: The bus wait equals the wait line of the selected slave. The wait lines of unselected slaves have no effect, and with no slave selected the decoder drives wait low.
- R9: While the bus wait is high, the selects and abort hold their values and the address, type and protection inputs are ignored. The held transfer is decoded on the first cycle the wait is low.
- R10: At most one select is high at any time, and abort is never high together with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Address from the active master |
| bus_trans | input | 2 | Transfer type of the next transfer |
| bus_prot | input | 2 | Protection field, bit 0 data/instruction, bit 1 privileged/user |
| slv_wait | input | NUM_REGIONS | Wait lines from the slaves |
| slv_sel | output | NUM_REGIONS | One-hot slave selects for the data phase |
| bus_wait | output | 1 | Wait response on the bus |
| bus_abort | output | 1 | Abort response on the bus |

## Verification
A stretched data phase and a new decode decision can fall in the same cycle. A selected slave raises its wait while the next address presented is unmapped and would abort. The bench checks that the select holds and abort stays low while the wait is high. It then checks that the abort for the queued address appears only in the cycle after the wait drops. Address matching and protection also combine in one decision. The sweep covers every address class under all four protection codes and all four transfer types. Each result is judged against a model in the bench that works from the region table by arithmetic.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_ADDR = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  // a transfer that owns a data phase
  function automatic logic needs_data(input logic [1:0] tr);
    return (tr == TR_NSEQ) || (tr == TR_SEQ);
  endfunction

endpackage

// File: rtl/bdp_region_match.sv
module bdp_region_match #(
  parameter int AW = 32,
  parameter int N  = 4,
  parameter logic [N*AW-1:0] BASE = '0,
  parameter logic [N*AW-1:0] MASK = '0
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    localparam logic [AW-1:0] RB = BASE[g*AW +: AW];
    localparam logic [AW-1:0] RM = MASK[g*AW +: AW];
    assign hit[g] = ((addr & RM) == RB);
  end
endmodule

// File: rtl/bdp_prio_pick.sv
module bdp_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/bdp_prot_check.sv
module bdp_prot_check #(
  parameter int N = 4,
  parameter logic [N-1:0] PRIV_ONLY = '0,
  parameter logic [N-1:0] NO_EXEC   = '0
) (
  input  logic [N-1:0] grant,
  input  logic [1:0]   prot,
  output logic         deny
);
  logic is_user, is_fetch, priv_hit, nx_hit;

  assign is_user  = !prot[1];
  assign is_fetch = !prot[0];
  assign priv_hit = |(grant & PRIV_ONLY);
  assign nx_hit   = |(grant & NO_EXEC);
  assign deny     = (is_user && priv_hit) || (is_fetch && nx_hit);
endmodule

// File: rtl/bdp_decoder.sv
module bdp_decoder
  import bdp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS*AW-1:0] REGION_BASE =
    {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_REGIONS*AW-1:0] REGION_MASK =
    {32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000, 32'hF000_0000},
  parameter logic [NUM_REGIONS-1:0] REGION_PRIV = 4'b0010,
  parameter logic [NUM_REGIONS-1:0] REGION_NX   = 4'b0100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic [1:0]             bus_trans,
  input  logic [1:0]             bus_prot,
  input  logic [NUM_REGIONS-1:0] slv_wait,
  output logic [NUM_REGIONS-1:0] slv_sel,
  output logic                   bus_wait,
  output logic                   bus_abort
);
  localparam int N = NUM_REGIONS;

  logic [N-1:0] hit, pick;
  logic         any_hit, deny, data_req;
  logic [N-1:0] sel_d, sel_q;
  logic         abort_d, abort_q;

  bdp_region_match #(.AW(AW), .N(N), .BASE(REGION_BASE), .MASK(REGION_MASK))
    u_match (.addr(bus_addr), .hit(hit));

  bdp_prio_pick #(.N(N))
    u_pick (.req(hit), .grant(pick), .any(any_hit));

  bdp_prot_check #(.N(N), .PRIV_ONLY(REGION_PRIV), .NO_EXEC(REGION_NX))
    u_prot (.grant(pick), .prot(bus_prot), .deny(deny));

  assign data_req = needs_data(bus_trans);

  always_comb begin
    sel_d   = '0;
    abort_d = 1'b0;
    if (data_req) begin
      if (!any_hit || deny) abort_d = 1'b1;
      else                  sel_d   = pick;
    end
  end

  // decision is taken only when the current data phase completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      abort_q <= 1'b0;
    end else if (!bus_wait) begin
      sel_q   <= sel_d;
      abort_q <= abort_d;
    end
  end

  assign slv_sel   = sel_q;
  assign bus_abort = abort_q;
  assign bus_wait  = |(sel_q & slv_wait);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_sel));

  // R10
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> (slv_sel == '0));

  // R8
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_sel == '0) |-> !bus_wait);

  // R9
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> ($stable(slv_sel) && $stable(bus_abort)));

  // R4
  no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wait && !bus_trans[1]) |=> (slv_sel == '0 && !bus_abort));

endmodule

// File: tb/bdp_decoder_bench.sv
module bdp_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_trans = 2'b00;
  logic [1:0]  bus_prot = 2'b00;
  logic [N-1:0] slv_wait = '0;
  logic [N-1:0] slv_sel;
  logic        bus_wait, bus_abort;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bdp_decoder u_bdp_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_trans(bus_trans),
    .bus_prot(bus_prot), .slv_wait(slv_wait), .slv_sel(slv_sel),
    .bus_wait(bus_wait), .bus_abort(bus_abort)
  );

  task automatic check(input string req, input logic [N-1:0] s_exp,
                       input logic a_exp, input logic w_exp);
    checks++;
    if (slv_sel !== s_exp || bus_abort !== a_exp || bus_wait !== w_exp) begin
      errors++;
      $display("FAIL %s: sel=%b abort=%b wait=%b expected sel=%b abort=%b wait=%b",
               req, slv_sel, bus_abort, bus_wait, s_exp, a_exp, w_exp);
    end
  endtask

  // region index from the default table, -1 when unmapped
  function automatic int region_of(input logic [31:0] a);
    case (a[31:28])
      4'h0: return 0;
      4'h1: return 1;
      4'h2: return (a[27:16] == 12'h000) ? 2 : 3;
      default: return -1;
    endcase
  endfunction

  task automatic run_one(input logic [31:0] a, input logic [1:0] tr,
                         input logic [1:0] pr);
    int r;
    logic [N-1:0] s_exp;
    logic a_exp;
    string req;
    @(negedge clk);
    bus_addr = a; bus_trans = tr; bus_prot = pr; slv_wait = '0;
    @(negedge clk);
    r = region_of(a);
    s_exp = '0; a_exp = 1'b0;
    if (tr < 2) req = "R4";
    else if (r < 0) begin req = "R7"; a_exp = 1'b1; end
    else if (r == 1 && !pr[1]) begin req = "R5"; a_exp = 1'b1; end
    else if (r == 2 && !pr[0]) begin req = "R6 R3"; a_exp = 1'b1; end
    else begin
      req = (r >= 2) ? "R3 R2" : "R2";
      s_exp = N'(1) << r;
    end
    check(req, s_exp, a_exp, 1'b0);
  endtask

  initial begin
    logic [31:0] lows [4];
    lows[0] = 32'h0000_0000; lows[1] = 32'h0000_FFFC;
    lows[2] = 32'h0001_0000; lows[3] = 32'h0FFF_FFFC;

    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);

    for (int hi = 0; hi < 16; hi++)
      for (int lo = 0; lo < 4; lo++)
        for (int tr = 0; tr < 4; tr++)
          for (int pr = 0; pr < 4; pr++)
            run_one({hi[3:0], 28'h0} | lows[lo], tr[1:0], pr[1:0]);

    // stretched phase on slave 1 with an unmapped address queued behind it
    run_one(32'h1000_0040, 2'b10, 2'b11);
    bus_addr = 32'h7000_0000; bus_trans = 2'b10; bus_prot = 2'b11;
    slv_wait = 4'b0001;
    #1 check("R8", 4'b0010, 1'b0, 1'b0);
    slv_wait = 4'b0010;
    #1 check("R8", 4'b0010, 1'b0, 1'b1);
    @(negedge clk);
    check("R9", 4'b0010, 1'b0, 1'b1);
    @(negedge clk);
    check("R9", 4'b0010, 1'b0, 1'b1);
    slv_wait = 4'b0000;
    #1 check("R8", 4'b0010, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 R7", 4'b0000, 1'b1, 1'b0);
    slv_wait = 4'b1111;
    #1 check("R8", 4'b0000, 1'b1, 1'b0);
    bus_trans = 2'b11; bus_addr = 32'h0000_1000; bus_prot = 2'b00;
    @(negedge clk);
    check("R10 R2", 4'b0001, 1'b0, 1'b1);
    slv_wait = '0; bus_trans = 2'b00;
    @(negedge clk);
    check("R4", 4'b0000, 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule